// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block is the controller-side engine that brings a synchronous DRAM from power-up into a programmed, usable state. It runs once after each reset. First it holds the device's inputs in a safe condition for a settling period, with clock enable high, the data mask high and a no-operation command on the pins. It then closes all banks with a precharge-all command and runs a fixed number of auto-refresh cycles, spacing each one by the row-cycle time. Finally it writes the mode register from three input fields and raises a done flag.

All waits are parameters counted in clock cycles. Every wait is measured from one command issue to the next. While done is low the sequencer owns the command pins, so the rest of the memory controller must hold off its requests. Once done rises it stays high until the next reset, and the sequencer then only drives NOP with DQM low.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low the outputs show NOP ({cs_n,ras_n,cas_n,we_n}=0111), cke_o=1, dqm_o=1, done_o=0, with addr_o and ba_o zero. cke_o is high at all times and dqm_o is high for as long as done_o is low.
- R2: After reset is released, NOP is held through the first STABLE_CYC rising edges. Precharge-all appears in the cycle after edge STABLE_CYC.
- R3: Precharge-all is encoded as 0010. addr_o bit 10 is high, all other address bits are zero and ba_o is zero.
- R4: The first auto-refresh is issued TRP_CYC cycles after the precharge-all, with NOP in the cycles between.
- R5: Exactly REF_NUM auto-refresh commands (0001, with addr_o and ba_o zero) are issued. Consecutive refreshes start TRC_CYC cycles apart, with NOP in the cycles between.
- R6: Mode register set (0000) is issued TRC_CYC cycles after the last refresh. It carries the field inputs on the address bus: burst-length code in addr_o[2:0], burst type in addr_o[3] (1 = interleaved), CAS-latency code in addr_o[6:4], all higher bits zero, ba_o zero.
- R7: done_o rises TMRD_CYC cycles after the mode register set. From then on the command is NOP and dqm_o is low.
- R8: done_o stays high until the next reset. Changes on the mode inputs after done have no effect on addr_o, which stays zero.
- R9: Asserting reset part-way through the sequence returns all outputs to the R1 state. The next release restarts the whole sequence from the hold period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bl_code_i | input | 3 | Burst-length code for the mode register |
| interleave_i | input | 1 | Burst type for the mode register: 1 = interleaved, 0 = sequential |
| cas_lat_i | input | 3 | CAS-latency code for the mode register |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | 1 | Data mask |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | BA_W | Bank address |
| done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
On every cycle the assertions check several properties. No non-NOP command appears before the hold period has elapsed. Precharge-all carries address bit 10. Each command keeps at least its minimum spacing from the one before it. The mode register set follows exactly REF_NUM refreshes. done is sticky, and DQM is high before done and low after it, with NOP only. The exact cycle of each command, the mode-field placement for different input words, the unchanged address after done, and the restart after a mid-sequence reset can only be shown by the bench scenarios, which count edges from reset release.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_HOLD, ST_PRE, ST_WAIT_RP, ST_REF, ST_WAIT_RC, ST_MRS, ST_WAIT_MRD, ST_DONE
  } init_st_e;

  localparam int unsigned PRE_ALL_BIT = 10;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  // terminal count: interval measured issue to issue
  assign hit_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/init_pin_drive.sv
module init_pin_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input  init_st_e            st_i,
  input  logic [2:0]          bl_code_i,
  input  logic                interleave_i,
  input  logic [2:0]          cas_lat_i,
  output sdr_cmd_e            cmd_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [BA_W-1:0]     ba_o,
  output logic                dqm_o,
  output logic                cke_o
);
  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    dqm_o  = (st_i != ST_DONE);
    cke_o  = 1'b1;
    unique case (st_i)
      ST_PRE: begin
        cmd_o               = CMD_PRE;
        addr_o[PRE_ALL_BIT] = 1'b1;
      end
      ST_REF: cmd_o = CMD_REF;
      ST_MRS: begin
        cmd_o       = CMD_MRS;
        addr_o[2:0] = bl_code_i;
        addr_o[3]   = interleave_i;
        addr_o[6:4] = cas_lat_i;
      end
      default: cmd_o = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 20000,
  parameter int unsigned TRP_CYC    = 3,
  parameter int unsigned TRC_CYC    = 7,
  parameter int unsigned TMRD_CYC   = 2,
  parameter int unsigned REF_NUM    = 8,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned BA_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bl_code_i,
  input  logic              interleave_i,
  input  logic [2:0]        cas_lat_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic              dqm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              done_o
);
  localparam int unsigned MAX_GAP = max_of4(STABLE_CYC, TRP_CYC, TRC_CYC, TMRD_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_GAP + 1);
  localparam int unsigned REF_W   = $clog2(REF_NUM + 1);

  init_st_e           st_q, st_d;
  logic [REF_W-1:0]   ref_q;
  logic [CNT_W-1:0]   limit;
  logic               hit, adv;
  sdr_cmd_e           cmd;

  always_comb begin
    st_d  = st_q;
    adv   = 1'b0;
    limit = CNT_W'(STABLE_CYC);
    unique case (st_q)
      ST_HOLD: if (hit) begin st_d = ST_PRE; adv = 1'b1; end
      ST_PRE:  st_d = ST_WAIT_RP;
      ST_WAIT_RP: begin
        limit = CNT_W'(TRP_CYC);
        if (hit) begin st_d = ST_REF; adv = 1'b1; end
      end
      ST_REF:  st_d = ST_WAIT_RC;
      ST_WAIT_RC: begin
        limit = CNT_W'(TRC_CYC);
        if (hit) begin
          adv  = 1'b1;
          st_d = (ref_q == REF_W'(REF_NUM)) ? ST_MRS : ST_REF;
        end
      end
      ST_MRS:  st_d = ST_WAIT_MRD;
      ST_WAIT_MRD: begin
        limit = CNT_W'(TMRD_CYC);
        if (hit) begin st_d = ST_DONE; adv = 1'b1; end
      end
      default: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      ref_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_REF) ref_q <= ref_q + 1'b1;
    end
  end

  init_gap_timer #(.W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (st_q != ST_DONE),
    .clr_i   (adv),
    .limit_i (limit),
    .hit_o   (hit)
  );

  init_pin_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .st_i         (st_q),
    .bl_code_i    (bl_code_i),
    .interleave_i (interleave_i),
    .cas_lat_i    (cas_lat_i),
    .cmd_o        (cmd),
    .addr_o       (addr_o),
    .ba_o         (ba_o),
    .dqm_o        (dqm_o),
    .cke_o        (cke_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
  import sdram_init_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 20000,
  parameter int unsigned TRP_CYC    = 3,
  parameter int unsigned TRC_CYC    = 7,
  parameter int unsigned TMRD_CYC   = 2,
  parameter int unsigned REF_NUM    = 8,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned BA_W       = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_i,
  input logic              ras_n_i,
  input logic              cas_n_i,
  input logic              we_n_i,
  input logic              cke_i,
  input logic              dqm_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BA_W-1:0]   ba_i,
  input logic              done_i
);
  logic [3:0]  cmd;
  logic        is_nop;
  int unsigned since_rst, gap, ref_seen;
  logic [3:0]  last_cmd;
  logic        mrs_seen;

  assign cmd    = {cs_n_i, ras_n_i, cas_n_i, we_n_i};
  assign is_nop = (cmd == CMD_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= 0;
      gap       <= 0;
      ref_seen  <= 0;
      last_cmd  <= CMD_NOP;
      mrs_seen  <= 1'b0;
    end else begin
      if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1;
      if (!is_nop) begin
        gap      <= 1;
        last_cmd <= cmd;
      end else if (gap != 32'hFFFF_FFFF) begin
        gap <= gap + 1;
      end
      if (cmd == CMD_REF) ref_seen <= ref_seen + 1;
      if (cmd == CMD_MRS) mrs_seen <= 1'b1;
    end
  end

  assert_hold_nop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_nop |-> since_rst >= STABLE_CYC);

  assert_pre_a10_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE) |-> (addr_i[PRE_ALL_BIT] && ba_i == '0));

  assert_pre_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_nop && last_cmd == CMD_PRE) |-> gap >= TRP_CYC);

  assert_ref_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_nop && last_cmd == CMD_REF) |-> gap >= TRC_CYC);

  assert_ref_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MRS) |-> ref_seen == REF_NUM);

  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (is_nop && !dqm_i && cke_i && mrs_seen));

  assert_mask_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> (dqm_i && cke_i));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);
endmodule

bind sdram_init_seq sdram_init_chk #(
  .STABLE_CYC(STABLE_CYC), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC),
  .TMRD_CYC(TMRD_CYC), .REF_NUM(REF_NUM), .ADDR_W(ADDR_W), .BA_W(BA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_i  (cs_n_o),
  .ras_n_i (ras_n_o),
  .cas_n_i (cas_n_o),
  .we_n_i  (we_n_o),
  .cke_i   (cke_o),
  .dqm_i   (dqm_o),
  .addr_i  (addr_o),
  .ba_i    (ba_o),
  .done_i  (done_o)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
  localparam int unsigned STABLE = 20;
  localparam int unsigned TRP    = 3;
  localparam int unsigned TRC    = 5;
  localparam int unsigned TMRD   = 2;
  localparam int unsigned NREF   = 8;
  localparam int unsigned AW     = 13;
  localparam int unsigned NSTEP  = NREF + 2;

  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;

  // step table: expected command and its issue-to-issue gap
  localparam logic [3:0] STEP_CMD [NSTEP] = '{C_PRE, C_REF, C_REF, C_REF, C_REF,
                                              C_REF, C_REF, C_REF, C_REF, C_MRS};
  localparam int unsigned STEP_GAP [NSTEP] = '{STABLE, TRP, TRC, TRC, TRC,
                                               TRC, TRC, TRC, TRC, TRC};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bl = 3'b010, cl = 3'b011;
  logic bt = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, dqm, done;
  logic [AW-1:0] addr;
  logic [1:0] ba;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(.STABLE_CYC(STABLE), .TRP_CYC(TRP), .TRC_CYC(TRC),
                   .TMRD_CYC(TMRD), .REF_NUM(NREF), .ADDR_W(AW), .BA_W(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bl_code_i(bl), .interleave_i(bt), .cas_lat_i(cl),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .cke_o(cke), .dqm_o(dqm), .addr_o(addr), .ba_o(ba), .done_o(done));

  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_state(input string req);
    chk(req, {cmd, cke, dqm, done}, {C_NOP, 1'b1, 1'b1, 1'b0});
    chk(req, {ba, addr}, '0);
  endtask

  task automatic run_seq(input logic [AW-1:0] mrs_addr);
    for (int s = 0; s < NSTEP; s++) begin
      string tag;
      int bad;
      logic [AW-1:0] exp_a;
      tag = (s == 0) ? "R2" : (s == 1) ? "R4" : (s == NSTEP-1) ? "R6" : "R5";
      bad = 0;
      for (int c = 0; c < int'(STEP_GAP[s]) - 1; c++) begin
        @(negedge clk);
        if (cmd !== C_NOP || dqm !== 1'b1 || cke !== 1'b1) bad++;
      end
      chk({tag, " nop gap"}, bad, 0);
      @(negedge clk);
      chk({tag, " cmd"}, cmd, STEP_CMD[s]);
      exp_a = (s == 0) ? AW'(13'h400) : (s == NSTEP-1) ? mrs_addr : '0;
      chk((s == 0) ? "R3 addr" : {tag, " addr"}, {ba, addr}, {2'b00, exp_a});
    end
    for (int c = 0; c < int'(TMRD) - 1; c++) begin
      @(negedge clk);
      chk("R7 done early", done, 1'b0);
    end
    @(negedge clk);
    chk("R7 done", {done, dqm, cke, cmd}, {1'b1, 1'b0, 1'b1, C_NOP});
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    idle_state("R1 reset");
    rst_n = 1'b1;
    run_seq(AW'(7'b0110010));

    // R8: mode changes after done leave the bus alone
    bl = 3'b111; bt = 1'b1; cl = 3'b010;
    repeat (6) @(negedge clk);
    chk("R8 sticky", {done, cmd}, {1'b1, C_NOP});
    chk("R8 addr", {ba, addr}, '0);

    // R9: reset part-way, then a full rerun with the new mode word
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (STABLE + 5) @(negedge clk);
    rst_n = 1'b0;
    #2;
    idle_state("R9 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    run_seq(AW'(7'b0101111));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule